// File: doc/BRIEF.md
# Graphics Masked and Block Write Datapath

This block forms the special write paths of a graphics synchronous DRAM with a 32-bit data bus. It decodes the active-low command strobes each clock, keeps for each bank whether a row is open and whether that row was opened with per-bit write masking, and holds two persistent registers: a 32-bit bit mask and a 32-bit fill color. Both are loaded by a special register-load cycle, which is marked by the special-function input.

For every accepted write it presents, one clock after the command, the bank, an eight-column-aligned column base, an eight-bit column enable, the write data and a per-bit write enable. A behavioural array applies these. Bits whose enable is low keep their old contents. A normal write enables one column and carries the bus data. A block write enables up to eight columns, chosen by bus bits 7..0, and carries the stored color.

Each bank runs a three-state machine. `BK_IDLE` moves to `BK_OPEN` on an activate without the special-function input, and to `BK_OPEN_MASKED` on an activate with it. Both open states return to `BK_IDLE` on a precharge to that bank. An activate to an open bank leaves its state unchanged.

Top module: `gfx_write_path`

## Requirements
- R1: A special load is sel_n=0, row_n=0, col_n=0, wr_n=0 with spec_fn=1. With addr[5]=0 it loads the bit mask from dq. With addr[5]=1 it loads the color from dq. It produces no write output.
- R2: The mask and color keep their values until the next special load. A load cycle with spec_fn=0 changes neither register.
- R3: A write command is sel_n=0, row_n=1, col_n=0, wr_n=0. If it is addressed to a bank that is not open, it produces no write output. Any cycle with sel_n=1 is a no-operation.
- R4: An activate (sel_n=0, row_n=0, col_n=1, wr_n=1) opens the addressed bank. If spec_fn=1 at activate, that bank is in masked mode until a precharge (sel_n=0, row_n=0, col_n=1, wr_n=0) closes it.
- R5: A normal write (spec_fn=0) to an open bank gives these outputs on the next clock: wr_valid=1, wr_block=0, wr_col = addr[7:0] with bits 2..0 cleared, wr_col_en one-hot at bit addr[2:0], and wr_data = dq.
- R6: A block write (write with spec_fn=1) to an open bank gives these outputs on the next clock: wr_block=1, wr_col aligned the same way, wr_col_en = dq[7:0], and wr_data = the color register.
- R7: wr_bit_en is the AND of two terms. The first is the byte enables: byte_mask[i]=1 clears bits 8i+7..8i. The second is the bit mask if the bank is in masked mode, and all ones otherwise.
- R8: After reset both banks are idle, the mask is all ones, the color is zero and wr_valid is 0.
- R9: wr_bank carries the bank of the write. Each bank's open state and masked mode are kept separately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Device select, active low |
| row_n | input | 1 | Row strobe, active low |
| col_n | input | 1 | Column strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| spec_fn | input | 1 | Special-function qualifier |
| bank | input | 1 | Bank address |
| addr | input | 10 | Multiplexed address; column in bits 7..0, register select in bit 5 |
| byte_mask | input | 4 | Byte masks, 1 masks a lane |
| dq | input | 32 | Data bus input |
| wr_valid | output | 1 | Write issued to array this cycle |
| wr_block | output | 1 | Write is a block write |
| wr_bank | output | 1 | Bank of the write |
| wr_col | output | 8 | Eight-aligned column base |
| wr_col_en | output | 8 | Per-column enables within the group |
| wr_bit_en | output | 32 | Per-bit write enables |
| wr_data | output | 32 | Data for the enabled columns |

## Verification
Three gates can act on a single write in the same cycle: the byte masks, the stored bit mask of a masked-mode bank, and the column enables of a block write. The bench opens a bank in masked mode. It then issues a block write that has one byte lane masked and a sparse column pattern on dq[7:0], and checks that the bit enable is exactly the stored mask with that lane cleared and that the column enable equals the pattern. It also loads a new mask in the cycle just before a write, and checks that the write uses the new value rather than the old one.

// File: rtl/gfx_write_pkg.sv
package gfx_write_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_ACT,
        CMD_WRITE,
        CMD_PRE,
        CMD_LOAD
    } gfx_cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE,
        BK_OPEN,
        BK_OPEN_MASKED
    } bank_state_e;

endpackage

// File: rtl/gfx_cmd_decode.sv
module gfx_cmd_decode
    import gfx_write_pkg::*;
(
    input  logic     sel_n,
    input  logic     row_n,
    input  logic     col_n,
    input  logic     wr_n,
    output gfx_cmd_e cmd
);
    always_comb begin
        cmd = CMD_NOP;
        if (!sel_n) begin
            unique case ({row_n, col_n, wr_n})
                3'b011:  cmd = CMD_ACT;
                3'b100:  cmd = CMD_WRITE;
                3'b010:  cmd = CMD_PRE;
                3'b000:  cmd = CMD_LOAD;
                default: cmd = CMD_NOP;
            endcase
        end
    end
endmodule

// File: rtl/gfx_bank_fsm.sv
module gfx_bank_fsm
    import gfx_write_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic act_hit,
    input  logic pre_hit,
    input  logic spec,
    output logic is_open,
    output logic is_masked
);
    bank_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BK_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BK_IDLE: begin
                if (act_hit) state_d = spec ? BK_OPEN_MASKED : BK_OPEN;
            end
            BK_OPEN, BK_OPEN_MASKED: begin
                if (pre_hit) state_d = BK_IDLE;
            end
            default: state_d = BK_IDLE;
        endcase
    end

    assign is_open   = (state_q != BK_IDLE);
    assign is_masked = (state_q == BK_OPEN_MASKED);

    p_open_on_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (act_hit && state_q == BK_IDLE) |=> (state_q != BK_IDLE));
    p_close_on_pre_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pre_hit |=> (state_q == BK_IDLE));
    p_mode_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != BK_IDLE && !pre_hit) |=> $stable(state_q));
endmodule

// File: rtl/gfx_spec_regs.sv
module gfx_spec_regs #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_hit,
    input  logic              sel_color,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] mask_q,
    output logic [DATA_W-1:0] color_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            color_q <= '0;
        end else if (load_hit) begin
            if (sel_color) color_q <= din;
            else           mask_q  <= din;
        end
    end

    p_mask_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_hit && !sel_color) |=> (mask_q == $past(din)));
    p_color_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (load_hit && sel_color) |=> (color_q == $past(din)));
    p_regs_persist_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !load_hit |=> ($stable(mask_q) && $stable(color_q)));
endmodule

// File: rtl/gfx_write_path.sv
module gfx_write_path
    import gfx_write_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NBANKS  = 2,
    parameter int ADDR_W  = 10,
    parameter int COL_W   = 8,
    parameter int NCOLS   = 8,
    parameter int SEL_BIT = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sel_n,
    input  logic                      row_n,
    input  logic                      col_n,
    input  logic                      wr_n,
    input  logic                      spec_fn,
    input  logic [$clog2(NBANKS)-1:0] bank,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [DATA_W/8-1:0]       byte_mask,
    input  logic [DATA_W-1:0]         dq,
    output logic                      wr_valid,
    output logic                      wr_block,
    output logic [$clog2(NBANKS)-1:0] wr_bank,
    output logic [COL_W-1:0]          wr_col,
    output logic [NCOLS-1:0]          wr_col_en,
    output logic [DATA_W-1:0]         wr_bit_en,
    output logic [DATA_W-1:0]         wr_data
);
    localparam int BANK_W = $clog2(NBANKS);
    localparam int NBYTES = DATA_W / 8;
    localparam int LOG_NC = $clog2(NCOLS);

    function automatic logic [DATA_W-1:0] lanes_on(input logic [NBYTES-1:0] m);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < NBYTES; i++) r[8*i +: 8] = {8{~m[i]}};
        return r;
    endfunction

    gfx_cmd_e cmd;
    logic [NBANKS-1:0] open_v, masked_v;
    logic [DATA_W-1:0] mask_q, color_q;

    gfx_cmd_decode u_dec (
        .sel_n(sel_n), .row_n(row_n), .col_n(col_n), .wr_n(wr_n), .cmd(cmd)
    );

    gfx_spec_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .load_hit(cmd == CMD_LOAD && spec_fn),
        .sel_color(addr[SEL_BIT]),
        .din(dq), .mask_q(mask_q), .color_q(color_q)
    );

    for (genvar b = 0; b < NBANKS; b++) begin : g_bank
        gfx_bank_fsm u_fsm (
            .clk(clk), .rst_n(rst_n),
            .act_hit(cmd == CMD_ACT && bank == BANK_W'(b)),
            .pre_hit(cmd == CMD_PRE && bank == BANK_W'(b)),
            .spec(spec_fn),
            .is_open(open_v[b]), .is_masked(masked_v[b])
        );
    end

    logic              go;
    logic [NCOLS-1:0]  col_en_d;
    logic [DATA_W-1:0] bit_en_d;
    logic [COL_W-1:0]  col_base_d;

    always_comb begin
        go         = (cmd == CMD_WRITE) && open_v[bank];
        col_base_d = {addr[COL_W-1:LOG_NC], {LOG_NC{1'b0}}};
        col_en_d   = spec_fn ? dq[NCOLS-1:0]
                             : (NCOLS'(1) << addr[LOG_NC-1:0]);
        bit_en_d   = lanes_on(byte_mask) & (masked_v[bank] ? mask_q : '1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_valid  <= 1'b0;
            wr_block  <= 1'b0;
            wr_bank   <= '0;
            wr_col    <= '0;
            wr_col_en <= '0;
            wr_bit_en <= '0;
            wr_data   <= '0;
        end else begin
            wr_valid <= go;
            if (go) begin
                wr_block  <= spec_fn;
                wr_bank   <= bank;
                wr_col    <= col_base_d;
                wr_col_en <= col_en_d;
                wr_bit_en <= bit_en_d;
                wr_data   <= spec_fn ? color_q : dq;
            end
        end
    end

    p_idle_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WRITE && !open_v[bank]) |=> !wr_valid);
    p_normal_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_block) |-> $onehot(wr_col_en));
    p_block_color_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (go && spec_fn) |=> (wr_data == $past(color_q)));
    p_byte_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> ((wr_bit_en & ~lanes_on($past(byte_mask))) == '0));
    p_bank_tag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (wr_bank == $past(bank)));
endmodule

// File: tb/gfx_write_path_tb.sv
module gfx_write_path_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_n = 1'b1, row_n = 1'b1, col_n = 1'b1, wr_n = 1'b1, spec_fn = 1'b0;
    logic bank = 1'b0;
    logic [9:0] addr = '0;
    logic [3:0] byte_mask = '0;
    logic [31:0] dq = '0;
    logic wr_valid, wr_block, wr_bank;
    logic [7:0] wr_col, wr_col_en;
    logic [31:0] wr_bit_en, wr_data;

    always #2 clk = ~clk;

    gfx_write_path u_dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .row_n(row_n), .col_n(col_n),
        .wr_n(wr_n), .spec_fn(spec_fn), .bank(bank), .addr(addr),
        .byte_mask(byte_mask), .dq(dq), .wr_valid(wr_valid), .wr_block(wr_block),
        .wr_bank(wr_bank), .wr_col(wr_col), .wr_col_en(wr_col_en),
        .wr_bit_en(wr_bit_en), .wr_data(wr_data)
    );

    typedef struct {
        logic valid, block, bnk;
        logic [7:0] col, col_en;
        logic [31:0] bit_en, data;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0, errors = 0;
    bit done = 1'b0;

    // Bench model, built from the requirements
    logic [31:0] m_mask = '1, m_color = '0;
    logic [1:0] m_open = '0, m_masked = '0;

    task automatic issue(input logic s, input logic r, input logic c, input logic w,
                         input logic sp, input logic b, input logic [9:0] a,
                         input logic [3:0] bm, input logic [31:0] d, input string tag);
        exp_t e;
        logic [31:0] lanes;
        @(negedge clk);
        sel_n = s; row_n = r; col_n = c; wr_n = w; spec_fn = sp;
        bank = b; addr = a; byte_mask = bm; dq = d;
        for (int i = 0; i < 4; i++) lanes[8*i +: 8] = {8{~bm[i]}};
        e.tag = tag; e.valid = 0; e.block = 0; e.bnk = b; e.col = {a[7:3], 3'b000};
        e.col_en = 0; e.bit_en = 0; e.data = 0;
        if (!s) begin
            if ({r, c, w} == 3'b100 && m_open[b]) begin
                e.valid  = 1;
                e.block  = sp;
                e.col_en = sp ? d[7:0] : (8'd1 << a[2:0]);
                e.data   = sp ? m_color : d;
                e.bit_en = lanes & (m_masked[b] ? m_mask : 32'hFFFF_FFFF);
            end else if ({r, c, w} == 3'b011 && !m_open[b]) begin
                m_open[b] = 1; m_masked[b] = sp;
            end else if ({r, c, w} == 3'b010) begin
                m_open[b] = 0; m_masked[b] = 0;
            end else if ({r, c, w} == 3'b000 && sp) begin
                if (a[5]) m_color = d; else m_mask = d;
            end
        end
        q.push_back(e);
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (wr_valid !== e.valid) begin
                    errors++;
                    $display("FAIL %s: wr_valid=%0b expected %0b", e.tag, wr_valid, e.valid);
                end else if (e.valid && (wr_block !== e.block || wr_bank !== e.bnk ||
                             wr_col !== e.col || wr_col_en !== e.col_en ||
                             wr_bit_en !== e.bit_en || wr_data !== e.data)) begin
                    errors++;
                    $display("FAIL %s: blk=%0b bank=%0b col=%h cen=%h ben=%h data=%h expected blk=%0b bank=%0b col=%h cen=%h ben=%h data=%h",
                             e.tag, wr_block, wr_bank, wr_col, wr_col_en, wr_bit_en, wr_data,
                             e.block, e.bnk, e.col, e.col_en, e.bit_en, e.data);
                end
            end
        end
    end

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if (wr_valid !== 1'b0) begin  // R8 reset state
            errors++;
            $display("FAIL R8: wr_valid=%0b expected 0", wr_valid);
        end
        @(negedge clk);
        rst_n = 1'b1;

        issue(0,1,0,0, 0,0, 10'd13, 4'h0, 32'h1111_2222, "R3 write to idle bank");
        issue(0,0,1,1, 0,0, 10'd0,  4'h0, 32'h0,         "R4 activate bank0 plain");
        issue(0,1,0,0, 0,0, 10'd13, 4'h0, 32'hA5A5_5A5A, "R5 normal write col 13");
        issue(0,1,0,0, 0,0, 10'd7,  4'h5, 32'h0102_0304, "R7 byte masks 0101");
        issue(0,0,0,0, 1,0, 10'h000, 4'h0, 32'h0F0F_F0F0, "R1 load mask");
        issue(0,0,0,0, 1,0, 10'h020, 4'h0, 32'hCAFE_BABE, "R1 load color");
        issue(0,0,0,0, 0,0, 10'h020, 4'h0, 32'hDEAD_0000, "R2 plain load ignored");
        issue(0,0,1,1, 1,1, 10'd0,  4'h0, 32'h0,         "R4 activate bank1 masked");
        issue(0,1,0,0, 0,1, 10'h27, 4'h0, 32'h7777_8888, "R9 masked write bank1");
        issue(0,1,0,0, 1,1, 10'h3B, 4'h8, 32'h0000_0096, "R6 block write masked+byte");
        issue(0,1,0,0, 1,0, 10'hF2, 4'h0, 32'hFFFF_FF01, "R6 block write bank0 color");
        issue(1,1,0,0, 0,0, 10'd3,  4'h0, 32'h1234_5678, "R3 deselected write");
        issue(0,0,1,0, 0,1, 10'd0,  4'h0, 32'h0,         "R4 precharge bank1");
        issue(0,1,0,0, 0,1, 10'd4,  4'h0, 32'h4444_4444, "R4 write after precharge");
        issue(0,0,1,1, 0,1, 10'd0,  4'h0, 32'h0,         "R4 reopen bank1 plain");
        issue(0,1,0,0, 0,1, 10'd4,  4'h2, 32'h5555_6666, "R4 plain mode bit enables");
        issue(0,0,1,0, 0,1, 10'd0,  4'h0, 32'h0,         "R4 precharge bank1 again");
        issue(0,0,1,1, 1,1, 10'd0,  4'h0, 32'h0,         "R4 reopen bank1 masked");
        issue(0,0,0,0, 1,1, 10'h000, 4'h0, 32'h1234_5678, "R2 reload mask");
        issue(0,1,0,0, 0,1, 10'hFF, 4'h0, 32'h9999_AAAA, "R2 new mask used at once");
        issue(0,1,0,0, 1,1, 10'h01, 4'h1, 32'h0000_0000, "R6 block write no columns");
        issue(1,1,1,1, 0,0, 10'd0,  4'h0, 32'h0,         "R3 idle tail");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule